// File: doc/BRIEF.md
# Color Sensor Register Slave on a Two-Wire Bus

This block gives a bus master access to the register set of a four-channel (red, green, blue, clear) light sensor over a two-wire serial bus. SCL and SDA are sampled through synchronizers in the core clock domain. The block finds START, repeated START and STOP conditions and answers only its own 7-bit device address. It drives SDA low to acknowledge bytes and to shift out read data. A register pointer is loaded by the first byte after an address+write. The pointer advances after every data byte, so both writes and reads may run in bursts.

The block holds the gain settings for each channel: a capacitor count and a 12-bit integration slot count. It also holds a mode register and a command register. A command bit asks an external converter for a colour measurement or a dark-offset capture. The request stays up until the converter pulses done and returns its results. The block stores those results in read-only registers and clears the command bit.

Top module: `clrsns_slave`

## Requirements
- R1: Only the device address 0x74 (first byte 0xE8 for write, 0xE9 for read) is acknowledged by pulling SDA low in the ninth clock. Every other address gets no acknowledge and the block ignores the bus until the next START.
- R2: START and repeated START are SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, or after the master NACKs a read byte, the block releases SDA.
- R3: A write is address+W, register pointer, then data bytes. The block acknowledges every byte. Each data byte goes to the pointer address and the pointer then advances by one.
- R4: A read is address+W, pointer, repeated START, address+R. Bytes go out MSB first from the pointer address, and the pointer advances after each byte until the master NACKs.
- R5: Command register 0x00 uses bit0 to request a measurement and bit1 to request an offset capture. `conv_req` is high while either bit is set, and `conv_offset` is 1 only when bit1 is set without bit0. The bit being serviced clears on `conv_done`, and the register reads 0x00 once both bits have cleared.
- R6: On a finished measurement, channel c's 10-bit result is readable at 0x40+2c (bits [7:0]) and 0x41+2c (bits [9:8] in bits [1:0], other bits 0). Channel order is red, green, blue, clear.
- R7: On a finished offset capture, channel c's sign-magnitude byte (bit7 = 1 negative, bits [6:0] magnitude) is readable unchanged at 0x48+c.
- R8: Mode register 0x01 holds bit0 trim, bit1 sleep and bit2 external clock. A write that sets sleep while bit2 is 0 stores sleep as 0. The three bits drive `trim_en`, `sleep_en` and `extclk_en`.
- R9: Capacitor registers 0x06+c hold 4 bits, reset to 0x0F, and read with bits [7:4] as 0. They appear on `cap_cfg[4c+3:4c]`.
- R10: Integration pairs sit at 0x0A+2c (bits [7:0]) and 0x0B+2c (bits [11:8] in the low nibble, upper nibble reads 0). They reset to 0 and appear on `int_cfg[12c+11:12c]`.
- R11: Writes to result, offset or unmapped addresses are acknowledged and change nothing. Reads of unmapped addresses return 0x00.
- R12: Driving `rst_n` low asynchronously returns every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| conv_req | output | 1 | Conversion requested |
| conv_offset | output | 1 | 1 = offset capture, 0 = colour measurement |
| conv_done | input | 1 | One-cycle pulse: results valid |
| conv_res | input | 40 | Four 10-bit results, channel 0 in the low bits |
| conv_ofs | input | 32 | Four sign-magnitude offset bytes, channel 0 low |
| cap_cfg | output | 16 | Capacitor settings, 4 bits per channel |
| int_cfg | output | 48 | Integration slot counts, 12 bits per channel |
| trim_en | output | 1 | Trim-offset mode |
| sleep_en | output | 1 | Sleep mode |
| extclk_en | output | 1 | External clock mode |

## Verification
A pad edge reaches the block's edge detector after two synchronizer flops and one history flop. The acknowledge and each read bit therefore appear on SDA three to four core cycles after the SCL fall that causes them. The bench holds every bus phase for eight core cycles and samples SDA in the middle of the SCL high phase, well after that delay. A register write or command takes effect on the cycle after the falling SCL edge that closes the eighth data bit. Conversion results are stored on the edge that samples `conv_done`. The bench reads port and register values only after the whole bus transaction or converter pulse has finished.

// File: rtl/clrsns_pkg.sv
package clrsns_pkg;

   typedef enum logic [3:0] {
      LK_IDLE, LK_ADDR, LK_ACK_ADDR, LK_PTR, LK_ACK_PTR,
      LK_WDATA, LK_ACK_WDATA, LK_RDATA, LK_RACK
   } link_st_e;

   // register map anchors (the converter side and software rely on these)
   localparam logic [7:0] MAP_CMD  = 8'h00;
   localparam logic [7:0] MAP_MODE = 8'h01;
   localparam logic [7:0] MAP_CAP  = 8'h06;
   localparam logic [7:0] MAP_INT  = 8'h0A;
   localparam logic [7:0] MAP_RES  = 8'h40;
   localparam logic [7:0] MAP_OFS  = 8'h48;

   localparam int CMD_MEAS  = 0;
   localparam int CMD_OFS   = 1;
   localparam int MODE_TRIM = 0;
   localparam int MODE_SLP  = 1;
   localparam int MODE_EXT  = 2;

endpackage

// File: rtl/clrsns_sync.sv
module clrsns_sync #(
   parameter int              W      = 2,
   parameter int              STAGES = 2,
   parameter logic [W-1:0]    INIT   = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= INIT;
            else        s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= {STAGES{INIT}};
            else        s_q <= {s_q[STAGES-2:0], d};
         end
         assign q = s_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/clrsns_link.sv
module clrsns_link
   import clrsns_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h74
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl,
   input  logic       sda,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic [7:0] rd_addr,
   input  logic [7:0] rd_data,
   output logic       bus_stop
);

   logic       scl_d, sda_d;
   logic       scl_rise, scl_fall, bus_start;
   link_st_e   st;
   logic [3:0] cnt;
   logic [7:0] shreg;
   logic [7:0] ptr;
   logic       rnw, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl;
         sda_d <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_d;
   assign scl_fall  = ~scl & scl_d;
   assign bus_start = scl & scl_d & sda_d & ~sda;
   assign bus_stop  = scl & scl_d & ~sda_d & sda;
   assign rd_addr   = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= LK_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         ptr     <= '0;
         rnw     <= 1'b0;
         mack    <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (bus_start) begin
            st     <= LK_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (bus_stop) begin
            st     <= LK_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               LK_ADDR, LK_PTR, LK_WDATA: begin
                  if (scl_rise && cnt < 4'd8) begin
                     shreg <= {shreg[6:0], sda};
                     cnt   <= 4'(cnt + 4'd1);
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     if (st == LK_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           rnw    <= shreg[0];
                           sda_oe <= 1'b1;
                           st     <= LK_ACK_ADDR;
                        end else begin
                           st <= LK_IDLE;
                        end
                     end else if (st == LK_PTR) begin
                        ptr    <= shreg;
                        sda_oe <= 1'b1;
                        st     <= LK_ACK_PTR;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 8'd1;
                        sda_oe  <= 1'b1;
                        st      <= LK_ACK_WDATA;
                     end
                  end
               end
               LK_ACK_ADDR: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rnw) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= LK_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= LK_PTR;
                     end
                  end
               end
               LK_ACK_PTR, LK_ACK_WDATA: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st     <= LK_WDATA;
                  end
               end
               LK_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 8'd1;
                        st     <= LK_RACK;
                     end else begin
                        cnt    <= 4'(cnt + 4'd1);
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               LK_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda;
                  end else if (scl_fall) begin
                     if (mack) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= LK_RDATA;
                     end else begin
                        st <= LK_IDLE;
                     end
                  end
               end
               default: st <= LK_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/clrsns_regs.sv
module clrsns_regs
   import clrsns_pkg::*;
#(
   parameter int CH_NUM = 4,
   parameter int RES_W  = 10,
   parameter int INT_W  = 12,
   parameter int CAP_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [7:0]              wr_addr,
   input  logic [7:0]              wr_data,
   input  logic [7:0]              rd_addr,
   output logic [7:0]              rd_data,
   input  logic                    conv_done,
   input  logic [CH_NUM*RES_W-1:0] conv_res,
   input  logic [CH_NUM*8-1:0]     conv_ofs,
   output logic                    conv_req,
   output logic                    conv_offset,
   output logic [CH_NUM*CAP_W-1:0] cap_cfg,
   output logic [CH_NUM*INT_W-1:0] int_cfg,
   output logic                    trim_en,
   output logic                    sleep_en,
   output logic                    extclk_en
);

   localparam int HI_INT = INT_W - 8;
   localparam int HI_RES = RES_W - 8;
   localparam logic [CAP_W-1:0] CAP_RST = '1;

   logic [1:0]                   cmd_q;
   logic [2:0]                   mode_q;
   logic [CH_NUM-1:0][CAP_W-1:0] cap_q;
   logic [CH_NUM-1:0][INT_W-1:0] int_q;
   logic [CH_NUM-1:0][RES_W-1:0] res_q;
   logic [CH_NUM-1:0][7:0]       ofs_q;
   logic                         meas_fin, ofs_fin;

   assign conv_req    = cmd_q[CMD_MEAS] | cmd_q[CMD_OFS];
   assign conv_offset = ~cmd_q[CMD_MEAS] & cmd_q[CMD_OFS];
   assign meas_fin    = conv_done & cmd_q[CMD_MEAS];
   assign ofs_fin     = conv_done & conv_offset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_en && wr_addr == MAP_CMD) begin
         cmd_q <= wr_data[1:0];
      end else begin
         if (meas_fin) cmd_q[CMD_MEAS] <= 1'b0;
         if (ofs_fin)  cmd_q[CMD_OFS]  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_en && wr_addr == MAP_MODE) begin
         mode_q[MODE_TRIM] <= wr_data[MODE_TRIM];
         mode_q[MODE_EXT]  <= wr_data[MODE_EXT];
         mode_q[MODE_SLP]  <= wr_data[MODE_SLP] & wr_data[MODE_EXT];
      end
   end

   assign trim_en   = mode_q[MODE_TRIM];
   assign sleep_en  = mode_q[MODE_SLP];
   assign extclk_en = mode_q[MODE_EXT];

   generate
      for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
         localparam logic [7:0] A_CAP = 8'(MAP_CAP + c);
         localparam logic [7:0] A_ILO = 8'(MAP_INT + 2 * c);
         localparam logic [7:0] A_IHI = 8'(MAP_INT + 2 * c + 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_q[c] <= CAP_RST;
               int_q[c] <= '0;
            end else if (wr_en) begin
               if (wr_addr == A_CAP) cap_q[c] <= wr_data[CAP_W-1:0];
               if (wr_addr == A_ILO) int_q[c][7:0] <= wr_data;
               if (wr_addr == A_IHI) int_q[c][INT_W-1:8] <= wr_data[HI_INT-1:0];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_q[c] <= '0;
               ofs_q[c] <= '0;
            end else begin
               if (meas_fin) res_q[c] <= conv_res[c*RES_W +: RES_W];
               if (ofs_fin)  ofs_q[c] <= conv_ofs[c*8 +: 8];
            end
         end

         assign cap_cfg[c*CAP_W +: CAP_W] = cap_q[c];
         assign int_cfg[c*INT_W +: INT_W] = int_q[c];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == MAP_CMD)  rd_data = {6'd0, cmd_q};
      if (rd_addr == MAP_MODE) rd_data = {5'd0, mode_q};
      for (int c = 0; c < CH_NUM; c++) begin
         if (rd_addr == 8'(MAP_CAP + c))         rd_data = 8'(cap_q[c]);
         if (rd_addr == 8'(MAP_INT + 2 * c))     rd_data = int_q[c][7:0];
         if (rd_addr == 8'(MAP_INT + 2 * c + 1)) rd_data = 8'(int_q[c][INT_W-1:8]);
         if (rd_addr == 8'(MAP_RES + 2 * c))     rd_data = res_q[c][7:0];
         if (rd_addr == 8'(MAP_RES + 2 * c + 1)) rd_data = 8'(res_q[c][RES_W-1:8]);
         if (rd_addr == 8'(MAP_OFS + c))         rd_data = ofs_q[c];
      end
   end

   logic unused_hi;
   assign unused_hi = (HI_RES > 0) ? 1'b0 : 1'b0;

endmodule

// File: rtl/clrsns_slave.sv
module clrsns_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h74,
   parameter int         SYNC_STAGES = 2,
   parameter int         CH_NUM      = 4,
   parameter int         RES_W       = 10,
   parameter int         INT_W       = 12,
   parameter int         CAP_W       = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe,
   output logic                    conv_req,
   output logic                    conv_offset,
   input  logic                    conv_done,
   input  logic [CH_NUM*RES_W-1:0] conv_res,
   input  logic [CH_NUM*8-1:0]     conv_ofs,
   output logic [CH_NUM*CAP_W-1:0] cap_cfg,
   output logic [CH_NUM*INT_W-1:0] int_cfg,
   output logic                    trim_en,
   output logic                    sleep_en,
   output logic                    extclk_en
);

   generate
      if (CH_NUM < 1 || CH_NUM > 4) begin : g_bad_ch
         $error("CH_NUM must lie in 1..4 to fit the register map");
      end
      if (RES_W < 9 || RES_W > 16) begin : g_bad_res
         $error("RES_W must lie in 9..16 (low/high byte pair)");
      end
      if (INT_W < 9 || INT_W > 16) begin : g_bad_int
         $error("INT_W must lie in 9..16 (low/high byte pair)");
      end
      if (CAP_W < 1 || CAP_W > 8) begin : g_bad_cap
         $error("CAP_W must lie in 1..8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [1:0] pad_s;
   logic       lk_wr_en, lk_stop;
   logic [7:0] lk_wr_addr, lk_wr_data, lk_rd_addr, lk_rd_data;

   clrsns_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (pad_s)
   );

   clrsns_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (pad_s[1]),
      .sda      (pad_s[0]),
      .sda_oe   (sda_oe),
      .wr_en    (lk_wr_en),
      .wr_addr  (lk_wr_addr),
      .wr_data  (lk_wr_data),
      .rd_addr  (lk_rd_addr),
      .rd_data  (lk_rd_data),
      .bus_stop (lk_stop)
   );

   clrsns_regs #(
      .CH_NUM (CH_NUM),
      .RES_W  (RES_W),
      .INT_W  (INT_W),
      .CAP_W  (CAP_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (lk_wr_en),
      .wr_addr     (lk_wr_addr),
      .wr_data     (lk_wr_data),
      .rd_addr     (lk_rd_addr),
      .rd_data     (lk_rd_data),
      .conv_done   (conv_done),
      .conv_res    (conv_res),
      .conv_ofs    (conv_ofs),
      .conv_req    (conv_req),
      .conv_offset (conv_offset),
      .cap_cfg     (cap_cfg),
      .int_cfg     (int_cfg),
      .trim_en     (trim_en),
      .sleep_en    (sleep_en),
      .extclk_en   (extclk_en)
   );

endmodule

// File: rtl/clrsns_chk.sv
module clrsns_chk #(
   parameter int CAPW = 16,
   parameter int INTW = 48
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sda_oe,
   input logic            bus_stop,
   input logic            wr_en,
   input logic            conv_req,
   input logic            conv_offset,
   input logic            conv_done,
   input logic            sleep_en,
   input logic            extclk_en,
   input logic [CAPW-1:0] cap_cfg,
   input logic [INTW-1:0] int_cfg
);

   // R2: a detected STOP frees the data line on the next cycle
   p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !sda_oe);

   // R5: a pending request stays up until the converter answers or software rewrites
   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done && !wr_en) |=> conv_req);

   // R5: a finished measurement is no longer requested
   p_meas_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_offset && conv_done && !wr_en) |=> !(conv_req && !conv_offset));

   // R8: sleep is only held together with the external clock mode
   p_sleep_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_en |-> extclk_en);

   // R9: capacitor settings change only through a bus write
   p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cap_cfg));

   // R10: integration settings change only through a bus write
   p_int_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(int_cfg));

endmodule

bind clrsns_slave clrsns_chk #(
   .CAPW (CH_NUM * CAP_W),
   .INTW (CH_NUM * INT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sda_oe      (sda_oe),
   .bus_stop    (lk_stop),
   .wr_en       (lk_wr_en),
   .conv_req    (conv_req),
   .conv_offset (conv_offset),
   .conv_done   (conv_done),
   .sleep_en    (sleep_en),
   .extclk_en   (extclk_en),
   .cap_cfg     (cap_cfg),
   .int_cfg     (int_cfg)
);

// File: tb/clrsns_slave_tb.sv
module clrsns_slave_tb;

   localparam int PH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_oe;
   logic        conv_req, conv_offset;
   logic        conv_done = 1'b0;
   logic [39:0] conv_res = '0;
   logic [31:0] conv_ofs = '0;
   logic [15:0] cap_cfg;
   logic [47:0] int_cfg;
   logic        trim_en, sleep_en, extclk_en;
   wire         sda_line = m_sda & ~sda_oe;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   clrsns_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .conv_req(conv_req), .conv_offset(conv_offset), .conv_done(conv_done),
      .conv_res(conv_res), .conv_ofs(conv_ofs), .cap_cfg(cap_cfg), .int_cfg(int_cfg),
      .trim_en(trim_en), .sleep_en(sleep_en), .extclk_en(extclk_en)
   );

   task automatic report();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic b_start();
      m_sda = 1'b1; wt(PH);
      m_scl = 1'b1; wt(PH);
      m_sda = 1'b0; wt(PH);
      m_scl = 1'b0; wt(PH);
   endtask

   task automatic b_stop();
      m_sda = 1'b0; wt(PH);
      m_scl = 1'b1; wt(PH);
      m_sda = 1'b1; wt(PH);
   endtask

   task automatic b_send(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wt(PH);
         m_scl = 1'b1; wt(PH);
         m_scl = 1'b0;
      end
      wt(PH);
      m_sda = 1'b1; wt(PH);
      m_scl = 1'b1; wt(PH / 2);
      ack = ~sda_line; wt(PH / 2);
      m_scl = 1'b0; wt(PH);
   endtask

   task automatic b_recv(input bit nack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(PH);
         m_scl = 1'b1; wt(PH / 2);
         b[i] = sda_line; wt(PH / 2);
         m_scl = 1'b0;
      end
      wt(PH);
      m_sda = nack; wt(PH);
      m_scl = 1'b1; wt(PH);
      m_scl = 1'b0; wt(PH);
      m_sda = 1'b1;
   endtask

   task automatic reg_wr(input logic [7:0] a, input int n, input logic [7:0] d [20]);
      bit ack;
      b_start();
      b_send(8'hE8, ack); chk(ack, "R3 addr ack", ack, 1);
      b_send(a, ack);     chk(ack, "R3 ptr ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         b_send(d[i], ack);
         chk(ack, "R3 data ack", ack, 1);
      end
      b_stop();
   endtask

   task automatic reg_wr1(input logic [7:0] a, input logic [7:0] v);
      logic [7:0] d [20];
      d[0] = v;
      reg_wr(a, 1, d);
   endtask

   task automatic reg_rd(input logic [7:0] a, input int n, output logic [7:0] q [20]);
      bit ack;
      b_start();
      b_send(8'hE8, ack); chk(ack, "R4 addr ack", ack, 1);
      b_send(a, ack);     chk(ack, "R4 ptr ack", ack, 1);
      b_start();
      b_send(8'hE9, ack); chk(ack, "R4 read addr ack", ack, 1);
      for (int i = 0; i < n; i++) b_recv(i == n - 1, q[i]);
      b_stop();
   endtask

   function automatic logic [7:0] rd1_dummy(input logic [7:0] x);
      return x;
   endfunction

   task automatic conv_answer();
      @(negedge clk);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      wt(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      logic [7:0] q [20];
      logic [7:0] d [20];
      logic [3:0] capv [4];
      logic [7:0] ilo [4];
      logic [7:0] ihi [4];
      logic [9:0] resv [4];
      logic [7:0] ofsv [4];
      logic [15:0] cap_exp;
      logic [47:0] int_exp;
      bit ack;

      wt(5);
      // R12 / R9 / R10 / R5: reset state at the ports
      chk(cap_cfg == 16'hFFFF, "R9 reset cap_cfg", cap_cfg, 16'hFFFF);
      chk(int_cfg == '0, "R10 reset int_cfg", int_cfg, 0);
      chk(conv_req == 1'b0, "R5 reset conv_req", conv_req, 0);
      chk(sda_oe == 1'b0, "R2 reset sda_oe", sda_oe, 0);
      rst_n = 1'b1;
      wt(5);

      // R4 / R9 / R10 / R11: burst read of the low map after reset
      reg_rd(8'h00, 18, q);
      for (int i = 0; i < 18; i++) begin
         logic [7:0] e;
         e = (i >= 6 && i <= 9) ? 8'h0F : 8'h00;
         chk(q[i] == e, "R9 R10 R11 reset readback", q[i], e);
      end

      // R1: sweep every 7-bit address
      for (int a = 0; a < 128; a++) begin
         b_start();
         b_send({7'(a), 1'b0}, ack);
         b_stop();
         chk(ack == (a == 'h74), "R1 address match", ack, a == 'h74);
      end

      // R3 / R9 / R10: burst write of caps and integration pairs
      for (int c = 0; c < 4; c++) begin
         capv[c] = 4'((c * 7 + 2) & 15);
         ilo[c]  = 8'(c * 59 + 28);
         ihi[c]  = 8'(224 + c * 5 + 3);
         d[c]    = {4'hA, capv[c]};
         d[4 + 2 * c] = ilo[c];
         d[5 + 2 * c] = ihi[c];
      end
      reg_wr(8'h06, 12, d);
      cap_exp = '0;
      int_exp = '0;
      for (int c = 0; c < 4; c++) begin
         cap_exp[c * 4 +: 4]  = capv[c];
         int_exp[c * 12 +: 12] = {ihi[c][3:0], ilo[c]};
      end
      chk(cap_cfg == cap_exp, "R9 cap_cfg after write", cap_cfg, cap_exp);
      chk(int_cfg == int_exp, "R10 int_cfg after write", int_cfg, int_exp);
      reg_rd(8'h06, 12, q);
      for (int c = 0; c < 4; c++) begin
         chk(q[c] == {4'h0, capv[c]}, "R9 cap readback", q[c], {4'h0, capv[c]});
         chk(q[4 + 2 * c] == ilo[c], "R10 int low readback", q[4 + 2 * c], ilo[c]);
         chk(q[5 + 2 * c] == {4'h0, ihi[c][3:0]}, "R10 int high readback",
             q[5 + 2 * c], {4'h0, ihi[c][3:0]});
      end

      // R8: mode register and the sleep rule
      reg_wr1(8'h01, 8'h03);
      reg_rd(8'h01, 1, q);
      chk(q[0] == 8'h01, "R8 sleep dropped without ext clock", q[0], 8'h01);
      chk(sleep_en == 1'b0 && trim_en == 1'b1, "R8 mode ports", {sleep_en, trim_en}, 2'b01);
      reg_wr1(8'h01, 8'h06);
      reg_rd(8'h01, 1, q);
      chk(q[0] == 8'h06, "R8 sleep kept with ext clock", q[0], 8'h06);
      chk(sleep_en && extclk_en && !trim_en, "R8 mode ports 2",
          {extclk_en, sleep_en, trim_en}, 3'b110);

      // R5 / R6: measurement request
      reg_wr1(8'h00, 8'h01);
      chk(conv_req && !conv_offset, "R5 measurement request", {conv_req, conv_offset}, 2'b10);
      reg_rd(8'h00, 1, q);
      chk(q[0] == 8'h01, "R5 command pending", q[0], 8'h01);
      for (int c = 0; c < 4; c++) begin
         resv[c] = 10'((c * 263 + 677) & 1023);
         conv_res[c * 10 +: 10] = resv[c];
      end
      conv_answer();
      chk(!conv_req, "R5 request dropped", conv_req, 0);
      reg_rd(8'h00, 1, q);
      chk(q[0] == 8'h00, "R5 command cleared", q[0], 8'h00);
      reg_rd(8'h40, 8, q);
      for (int c = 0; c < 4; c++) begin
         chk(q[2 * c] == resv[c][7:0], "R6 result low", q[2 * c], resv[c][7:0]);
         chk(q[2 * c + 1] == {6'd0, resv[c][9:8]}, "R6 result high",
             q[2 * c + 1], {6'd0, resv[c][9:8]});
      end

      // R5 / R7: offset capture
      reg_wr1(8'h00, 8'h02);
      chk(conv_req && conv_offset, "R5 offset request", {conv_req, conv_offset}, 2'b11);
      for (int c = 0; c < 4; c++) begin
         ofsv[c] = 8'((c * 83 + 129) & 255);
         conv_ofs[c * 8 +: 8] = ofsv[c];
      end
      conv_answer();
      reg_rd(8'h48, 4, q);
      for (int c = 0; c < 4; c++)
         chk(q[c] == ofsv[c], "R7 offset byte", q[c], ofsv[c]);

      // R5: both bits, measurement served first
      reg_wr1(8'h00, 8'h03);
      chk(conv_req && !conv_offset, "R5 both: measurement first", conv_offset, 0);
      conv_answer();
      chk(conv_req && conv_offset, "R5 both: offset next", {conv_req, conv_offset}, 2'b11);
      conv_answer();
      reg_rd(8'h00, 1, q);
      chk(q[0] == 8'h00 && !conv_req, "R5 both cleared", q[0], 0);

      // R11: writes to read-only and unmapped addresses are ignored
      reg_wr1(8'h40, 8'h55);
      reg_wr1(8'h48, 8'h55);
      reg_wr1(8'h20, 8'h77);
      reg_rd(8'h40, 1, q);
      chk(q[0] == resv[0][7:0], "R11 result not writable", q[0], resv[0][7:0]);
      reg_rd(8'h48, 1, q);
      chk(q[0] == ofsv[0], "R11 offset not writable", q[0], ofsv[0]);
      reg_rd(8'h20, 1, q);
      chk(q[0] == 8'h00, "R11 unmapped reads zero", q[0], 0);
      chk(cap_cfg == cap_exp && int_cfg == int_exp, "R11 settings untouched", cap_cfg, cap_exp);

      // R2: line released after NACK and STOP
      chk(sda_oe == 1'b0, "R2 released after read", sda_oe, 0);

      // R12: asynchronous reset restores everything
      @(negedge clk);
      #1 rst_n = 1'b0;
      #1;
      chk(cap_cfg == 16'hFFFF && int_cfg == '0, "R12 async reset", cap_cfg, 16'hFFFF);
      chk(!sleep_en && !extclk_en, "R12 mode reset", {extclk_en, sleep_en}, 0);
      wt(3);
      rst_n = 1'b1;
      wt(3);
      reg_rd(8'h40, 1, q);
      chk(q[0] == 8'h00, "R12 result reset", q[0], 0);

      report();
   end

endmodule